// File: doc/BRIEF.md
# Video Field Capture Decimator

This block decides, one video field at a time, whether the pixels of that field reach the pixel output port. A 3-bit mode code selects a pass pattern. The patterns are: nothing, every field, every fourth field, every second field, fields of one parity only, or every second field of one parity. The block samples a field-start strobe together with a parity flag. At that moment it makes the decision for the coming field and holds it until the next strobe. The held decision gates the incoming pixel-valid signal.

A small byte-wide register port holds the mode code and a 10-bit programmable delay value. The delay value is split over a low byte and a two-bit high part. The delay value is only stored and driven out for a neighbouring block. Writing the mode code restarts the decimation counting, so the first field after the write is passed in every counting mode.

Top module: `fieldCaptureGate`

## Requirements
- R1: After reset, the mode reads 0, the delay low byte reads 0x52, the delay high register reads 0x00, `captureOn` is 0 and `pixValidOut` is 0.
- R2: In mode 0 (capture off), no field is captured, whatever its parity.
- R3: In mode 1, the first field after a mode write is captured, then one in every four fields is captured, regardless of parity.
- R4: In mode 2, the first field after a mode write is captured, then every second field is captured. Writing the mode again restarts the count, so the next field is captured.
- R5: In mode 3 (`fieldOdd`=1 fields) and mode 4 (`fieldOdd`=0 fields), only fields of the selected parity advance the count. The first such field after the write is captured and then every second one. Fields of the other parity are never captured.
- R6: Mode 5 captures exactly the odd fields (`fieldOdd`=1), mode 6 exactly the even fields, and mode 7 every field.
- R7: The decision is taken at the clock edge where `fieldStart` is high and takes effect one cycle later. It stays constant until the next `fieldStart`. A mode write during a field does not change the current field's decision.
- R8: `pixValidOut` is high only in cycles where `pixValidIn` is high and the current field is captured.
- R9: Register address 1 holds delay bits 7..0. Address 2 holds delay bits 9..8 in its data bits 1..0. Writes to bits 7..2 of address 2 are ignored, and those bits read as 0. `delayValue` shows the stored value one cycle after the write. Address 3 ignores writes and reads 0.
- R10: Register address 0 holds the mode code in data bits 2..0. Bits 7..3 of a write are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fieldStart | input | 1 | One-cycle strobe at the start of each field |
| fieldOdd | input | 1 | Parity of the starting field, 1 = odd |
| pixValidIn | input | 1 | Pixel-valid from the upstream pixel path |
| pixValidOut | output | 1 | Gated pixel-valid to the output port |
| captureOn | output | 1 | Decision held for the current field |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| delayValue | output | 10 | Stored programmable delay |

## Verification
All eight modes are driven with field sequences of alternating parity. This shows whether a mode counts every field or only fields of one parity. Modes 3 and 4 are also run with sequences that start on the opposite parity. Those runs separate a counter that advances on every field from one that advances only on the selected parity. A mode write repeated between fields, and a mode write in the middle of a field, show whether the counter restarts on each write and whether the decision stays held for the whole field. Pixel-valid is toggled inside each field to check the gating in both the captured and the dropped case.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DLY_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DLY_HI = 2'd2;

  typedef enum logic [MODE_W-1:0] {
    CAP_NONE      = 3'd0,
    CAP_QUARTER   = 3'd1,
    CAP_HALF      = 3'd2,
    CAP_HALF_ODD  = 3'd3,
    CAP_HALF_EVEN = 3'd4,
    CAP_ODD       = 3'd5,
    CAP_EVEN      = 3'd6,
    CAP_ALL       = 3'd7
  } capMode_e;

  typedef struct packed {
    logic modeWritten;
    logic fieldStrobe;
    logic fieldOdd;
  } ctrlStrobes_t;
endpackage

// File: rtl/fcg_ctrl.sv
module fcg_ctrl
  import fcg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DELAY_W   = 10,
  parameter int DELAY_RST = 10'h052
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic                fieldStart,
  input  logic                fieldOdd,
  output capMode_e            mode,
  output logic [DELAY_W-1:0]  delayValue,
  output logic [DATA_W-1:0]   regRdata,
  output ctrlStrobes_t        strb
);
  localparam int HI_W = DELAY_W - DATA_W;
  localparam logic [DELAY_W-1:0] RST_VAL = DELAY_W'(DELAY_RST);

  logic [DATA_W-1:0] dlyLo;
  logic [HI_W-1:0]   dlyHi;
  logic              wrMode;

  assign wrMode = regWe && (regAddr == ADDR_MODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode  <= CAP_NONE;
      dlyLo <= RST_VAL[DATA_W-1:0];
      dlyHi <= RST_VAL[DELAY_W-1:DATA_W];
    end else if (regWe) begin
      case (regAddr)
        ADDR_MODE:   mode  <= capMode_e'(regWdata[MODE_W-1:0]);
        ADDR_DLY_LO: dlyLo <= regWdata;
        ADDR_DLY_HI: dlyHi <= regWdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_MODE:   regRdata[MODE_W-1:0] = mode;
      ADDR_DLY_LO: regRdata = dlyLo;
      ADDR_DLY_HI: regRdata[HI_W-1:0] = dlyHi;
      default: ;
    endcase
  end

  assign delayValue       = {dlyHi, dlyLo};
  assign strb.modeWritten = wrMode;
  assign strb.fieldStrobe = fieldStart;
  assign strb.fieldOdd    = fieldOdd;
endmodule

// File: rtl/fcg_datapath.sv
module fcg_datapath
  import fcg_pkg::*;
#(
  parameter int QUARTER_N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  capMode_e     mode,
  input  ctrlStrobes_t strb,
  input  logic         pixValidIn,
  output logic         captureOn,
  output logic         pixValidOut
);
  localparam int CNT_W = $clog2(QUARTER_N);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wrapAt;
  logic [CNT_W-1:0] cntNext;
  logic             decide;
  logic             advance;

  always_comb begin
    decide  = 1'b0;
    advance = 1'b0;
    wrapAt  = CNT_W'(1);
    case (mode)
      CAP_NONE: ;
      CAP_QUARTER: begin
        wrapAt  = CNT_W'(QUARTER_N - 1);
        decide  = (cnt == '0);
        advance = 1'b1;
      end
      CAP_HALF: begin
        decide  = (cnt == '0);
        advance = 1'b1;
      end
      CAP_HALF_ODD: begin
        decide  = strb.fieldOdd && (cnt == '0);
        advance = strb.fieldOdd;
      end
      CAP_HALF_EVEN: begin
        decide  = !strb.fieldOdd && (cnt == '0);
        advance = !strb.fieldOdd;
      end
      CAP_ODD:  decide = strb.fieldOdd;
      CAP_EVEN: decide = !strb.fieldOdd;
      CAP_ALL:  decide = 1'b1;
      default: ;
    endcase
    cntNext = (cnt >= wrapAt) ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      captureOn <= 1'b0;
    end else begin
      if (strb.modeWritten) begin
        cnt <= '0;
      end else if (strb.fieldStrobe && advance) begin
        cnt <= cntNext;
      end
      if (strb.fieldStrobe) begin
        captureOn <= decide;
      end
    end
  end

  assign pixValidOut = pixValidIn & captureOn;
endmodule

// File: rtl/fieldCaptureGate.sv
module fieldCaptureGate
  import fcg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DELAY_W   = 10,
  parameter int DELAY_RST = 10'h052,
  parameter int QUARTER_N = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fieldStart,
  input  logic               fieldOdd,
  input  logic               pixValidIn,
  output logic               pixValidOut,
  output logic               captureOn,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [DELAY_W-1:0] delayValue
);
  capMode_e     mode;
  ctrlStrobes_t strb;

  fcg_ctrl #(
    .DATA_W(DATA_W), .DELAY_W(DELAY_W), .DELAY_RST(DELAY_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
    .mode(mode), .delayValue(delayValue), .regRdata(regRdata), .strb(strb)
  );

  fcg_datapath #(.QUARTER_N(QUARTER_N)) u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb),
    .pixValidIn(pixValidIn), .captureOn(captureOn), .pixValidOut(pixValidOut)
  );
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       fieldStart,
  input logic       fieldOdd,
  input logic       pixValidIn,
  input logic       pixValidOut,
  input logic       captureOn,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic [9:0] delayValue
);
  logic [2:0] shadowMode;

  always_ff @(posedge clk) begin
    if (!rstN) shadowMode <= 3'd0;
    else if (regWe && regAddr == 2'd0) shadowMode <= regWdata[2:0];
  end

  a_r2_off_drops: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart && shadowMode == 3'd0 |=> !captureOn);
  a_r6_all_kept: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart && shadowMode == 3'd7 |=> captureOn);
  a_r6_odd_only: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart && shadowMode == 3'd5 |=> captureOn == $past(fieldOdd));
  a_r6_even_only: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart && shadowMode == 3'd6 |=> captureOn == !$past(fieldOdd));
  a_r7_held_in_field: assert property (@(posedge clk) disable iff (!rstN)
    !fieldStart |=> $stable(captureOn));
  a_r8_gate: assert property (@(posedge clk) disable iff (!rstN)
    pixValidOut |-> pixValidIn && captureOn);
  a_r9_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 2'd2 |-> regRdata[7:2] == 6'd0);
  a_r9_hi_write: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == 2'd2 |=> delayValue[9:8] == $past(regWdata[1:0]));
  a_r9_lo_write: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == 2'd1 |=> delayValue[7:0] == $past(regWdata));
  a_r10_mode_read: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 2'd0 |-> regRdata == {5'd0, shadowMode});
endmodule

bind fieldCaptureGate fcg_checker u_chk (
  .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
  .pixValidIn(pixValidIn), .pixValidOut(pixValidOut), .captureOn(captureOn),
  .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .delayValue(delayValue)
);

// File: tb/sim_fieldCaptureGate.sv
`timescale 1ns/1ps
module sim_fieldCaptureGate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldStart = 1'b0, fieldOdd = 1'b0, pixValidIn = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic pixValidOut, captureOn;
  logic [7:0] regRdata;
  logic [9:0] delayValue;

  always #2 clk = ~clk;

  fieldCaptureGate u0 (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
    .pixValidIn(pixValidIn), .pixValidOut(pixValidOut), .captureOn(captureOn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .delayValue(delayValue)
  );

  typedef struct { bit val; string tag; } exp_t;
  exp_t expQ[$];
  int total = 0, bad = 0;
  bit finished = 0;
  int mMode = 0, mCnt = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit modelField(bit odd);
    bit r = 0;
    case (mMode)
      1: begin r = (mCnt == 0); mCnt = (mCnt + 1) % 4; end
      2: begin r = (mCnt == 0); mCnt = (mCnt + 1) % 2; end
      3: if (odd)  begin r = (mCnt == 0); mCnt = (mCnt + 1) % 2; end
      4: if (!odd) begin r = (mCnt == 0); mCnt = (mCnt + 1) % 2; end
      5: r = odd;
      6: r = !odd;
      7: r = 1;
      default: r = 0;
    endcase
    return r;
  endfunction

  // Monitor: the cycle after a field strobe, compare the held decision.
  always @(negedge clk) begin
    if (rstN && fieldStart && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, captureOn, e.val);
    end
  end

  task automatic writeReg(bit [1:0] a, bit [7:0] d);
    @(negedge clk);
    regWe <= 1'b1; regAddr <= a; regWdata <= d;
    @(negedge clk);
    regWe <= 1'b0;
    if (a == 2'd0) begin mMode = d & 8'h7; mCnt = 0; end
  endtask

  task automatic readCheck(bit [1:0] a, int exp, string tag);
    @(negedge clk);
    regAddr <= a;
    #1 check(tag, regRdata, exp);
  endtask

  task automatic field(bit odd, string tag);
    bit e;
    e = modelField(odd);
    @(negedge clk);
    fieldStart <= 1'b1; fieldOdd <= odd;
    expQ.push_back('{e, tag});
    @(negedge clk);
    fieldStart <= 1'b0;
    for (int i = 0; i < 2; i++) begin
      pixValidIn <= (i == 0);
      #1 check("R8", pixValidOut, (i == 0) && e);
      @(negedge clk);
    end
    pixValidIn <= 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN <= 1'b1;
    // R1 reset state
    readCheck(2'd0, 8'h00, "R1");
    readCheck(2'd1, 8'h52, "R1");
    readCheck(2'd2, 8'h00, "R1");
    check("R1", delayValue, 10'h052);
    check("R1", captureOn, 0);
    pixValidIn <= 1'b1;
    #1 check("R1", pixValidOut, 0);
    @(negedge clk) pixValidIn <= 1'b0;
    // R2 capture off
    field(1, "R2"); field(0, "R2"); field(1, "R2");
    // R10 upper bits ignored, mode 1
    writeReg(2'd0, 8'hF9);
    readCheck(2'd0, 8'h01, "R10");
    for (int i = 0; i < 8; i++) field(i[0] == 0, "R3");
    // R4 every second, restart on rewrite
    writeReg(2'd0, 8'h02);
    for (int i = 0; i < 5; i++) field(i[0] == 1, "R4");
    writeReg(2'd0, 8'h02);
    field(0, "R4"); field(1, "R4");
    // R5 parity-specific halves, both starting parities
    writeReg(2'd0, 8'h03);
    for (int i = 0; i < 6; i++) field(i[0] == 0, "R5");
    writeReg(2'd0, 8'h03);
    for (int i = 0; i < 6; i++) field(i[0] == 1, "R5");
    writeReg(2'd0, 8'h04);
    for (int i = 0; i < 6; i++) field(i[0] == 1, "R5");
    writeReg(2'd0, 8'h04);
    for (int i = 0; i < 6; i++) field(i[0] == 0, "R5");
    // R6 parity and all
    writeReg(2'd0, 8'h05);
    field(1, "R6"); field(0, "R6"); field(1, "R6");
    writeReg(2'd0, 8'h06);
    field(1, "R6"); field(0, "R6"); field(0, "R6");
    writeReg(2'd0, 8'h07);
    field(0, "R6"); field(1, "R6"); field(1, "R6");
    // R7 mid-field mode write keeps current decision
    writeReg(2'd0, 8'h00);
    check("R7", captureOn, 1);
    pixValidIn <= 1'b1;
    #1 check("R7", pixValidOut, 1);
    @(negedge clk) pixValidIn <= 1'b0;
    field(1, "R7");
    check("R7", captureOn, 0);
    // R9 delay registers
    writeReg(2'd1, 8'hA5);
    writeReg(2'd2, 8'hFF);
    readCheck(2'd2, 8'h03, "R9");
    readCheck(2'd1, 8'hA5, "R9");
    check("R9", delayValue, 10'h3A5);
    writeReg(2'd3, 8'h77);
    readCheck(2'd3, 8'h00, "R9");
    check("R9", delayValue, 10'h3A5);
    readCheck(2'd0, 8'h00, "R10");
    repeat (2) @(negedge clk);
    check("R7", expQ.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule